// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block resolves the data and control hazards of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Every cycle it compares the two source register numbers held in the decode/execute pipeline register with the destination numbers in the execute/memory and memory/write-back registers. From those comparisons it picks, separately for each ALU operand, the path the operand comes from: the register file, the execute/memory result or the write-back result.

A load whose data is needed by the instruction right behind it cannot be covered by any bypass. When that happens the unit freezes the program counter and the fetch/decode register and sends a bubble into execute for one cycle. Branches are assumed not taken. When one resolves taken, the unit flushes the one wrong-path instruction that was fetched behind it. The whole unit is combinational: its outputs follow its inputs within the same cycle and drive the surrounding datapath's muxes and register enables.

Top module: `hazard_unit`

## Requirements
- R1: When every input is zero, both operand selects are 2'b00 and pcHold, ifIdHold, ifIdFlush and idExBubble are all 0.
- R2: When memRegWrite is 1, memRd is nonzero and memRd equals an operand's execute-stage source, that operand's select is 2'b10 (execute/memory result).
- R3: When the execute/memory stage gives no match, and wbRegWrite is 1, wbRd is nonzero and wbRd equals the operand's source, the select is 2'b01 (write-back result). In every other case it is 2'b00 (register file).
- R4: When both later stages match the same operand, the select is 2'b10, because the newer result wins.
- R5: A destination of register 0, or a producer whose register-write flag is 0, never causes forwarding or a stall.
- R6: The select for operand A (exRs1) and the select for operand B (exRs2) are chosen independently of each other.
- R7: When exMemRead and exRegWrite are 1, exRd is nonzero and exRd equals idRs1 or idRs2, then pcHold, ifIdHold and idExBubble are all 1.
- R8: When a producer in execute is not a load (exMemRead is 0), a register match raises no stall.
- R9: When branchTaken is 1, ifIdFlush is 1.
- R10: When branchTaken and a load-use hit occur in the same cycle, ifIdFlush is 1, pcHold and ifIdHold are 0, and idExBubble stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idRs1 | input | 5 | First source register of the instruction in decode |
| idRs2 | input | 5 | Second source register of the instruction in decode |
| exRs1 | input | 5 | Operand A source register in the decode/execute register |
| exRs2 | input | 5 | Operand B source register in the decode/execute register |
| exRd | input | 5 | Destination register of the instruction in execute |
| exRegWrite | input | 1 | Instruction in execute writes a register |
| exMemRead | input | 1 | Instruction in execute is a load |
| memRd | input | 5 | Destination register in the execute/memory register |
| memRegWrite | input | 1 | Execute/memory instruction writes a register |
| wbRd | input | 5 | Destination register in the memory/write-back register |
| wbRegWrite | input | 1 | Memory/write-back instruction writes a register |
| branchTaken | input | 1 | A branch resolved taken this cycle |
| fwdA | output | 2 | Operand A select: 00 register file, 10 exec/mem, 01 write-back |
| fwdB | output | 2 | Operand B select, same encoding |
| pcHold | output | 1 | Keep the program counter unchanged |
| ifIdHold | output | 1 | Keep the fetch/decode register unchanged |
| ifIdFlush | output | 1 | Clear the fetch/decode register to a no-op |
| idExBubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The bench targets the case where both later stages hold the same destination. If priority were reversed there, a stale write-back value would reach the ALU. It also covers register 0 and cleared write flags, which a careless design would forward or stall on as spurious hazards. A load-use match is tried through each decode source, and a non-load producer is checked so that no needless stall appears. Finally, a taken branch is raised in the same cycle as a load-use hit: a design that lets the hold win would keep the wrong-path instruction in decode.

// File: rtl/hu_pkg.sv
package hu_pkg;
  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_WB    = 2'b01,
    FWD_EXMEM = 2'b10
  } fwdSel_e;

  // strobes passed from the comparator datapath to the freeze control
  typedef struct packed {
    logic loadUse;
    logic redirect;
  } hzStrobe_t;
endpackage

// File: rtl/hu_fwd_path.sv
module hu_fwd_path
  import hu_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int NS = NUM_SRC
) (
  input  logic [RW-1:0] exSrc [NS],
  input  logic [RW-1:0] idSrc [NS],
  input  logic [RW-1:0] exRd,
  input  logic          exRegWrite,
  input  logic          exMemRead,
  input  logic [RW-1:0] memRd,
  input  logic          memRegWrite,
  input  logic [RW-1:0] wbRd,
  input  logic          wbRegWrite,
  input  logic          branchTaken,
  output fwdSel_e       fwdSel [NS],
  output hzStrobe_t     strobes
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic memLive, wbLive, exLoadLive;
  logic [NS-1:0] useHit;

  assign memLive    = memRegWrite && (memRd != ZERO_REG);
  assign wbLive     = wbRegWrite && (wbRd != ZERO_REG);
  assign exLoadLive = exMemRead && exRegWrite && (exRd != ZERO_REG);

  for (genvar s = 0; s < NS; s++) begin : g_src
    logic memHit, wbHit;
    assign memHit = memLive && (memRd == exSrc[s]);
    assign wbHit  = wbLive && (wbRd == exSrc[s]);
    assign useHit[s] = exLoadLive && (exRd == idSrc[s]);

    always_comb begin
      if (memHit)     fwdSel[s] = FWD_EXMEM;
      else if (wbHit) fwdSel[s] = FWD_WB;
      else            fwdSel[s] = FWD_RF;
    end

    always_comb begin
      AST_SEL_LEGAL: assert (fwdSel[s] != 2'b11); // R3
      if (exSrc[s] == ZERO_REG)
        AST_NO_R0_FWD: assert (fwdSel[s] == FWD_RF); // R5
      if (!memRegWrite && !wbRegWrite)
        AST_NO_WRITE_NO_FWD: assert (fwdSel[s] == FWD_RF); // R5
    end
  end

  assign strobes.loadUse  = |useHit;
  assign strobes.redirect = branchTaken;

  always_comb begin
    if (!exMemRead)
      AST_LOAD_ONLY_STALL: assert (!strobes.loadUse); // R8
  end
endmodule

// File: rtl/hu_ctrl.sv
module hu_ctrl
  import hu_pkg::*;
(
  input  hzStrobe_t strobes,
  output logic      pcHold,
  output logic      ifIdHold,
  output logic      ifIdFlush,
  output logic      idExBubble
);
  logic freezeFront;

  // a redirect takes precedence over a freeze of the front end
  assign freezeFront = strobes.loadUse && !strobes.redirect;
  assign pcHold      = freezeFront;
  assign ifIdHold    = freezeFront;
  assign ifIdFlush   = strobes.redirect;
  assign idExBubble  = strobes.loadUse;

  always_comb begin
    AST_HOLD_PAIR: assert (pcHold == ifIdHold); // R7
    AST_FLUSH_WINS: assert (!(ifIdHold && ifIdFlush)); // R10
    if (pcHold)
      AST_HOLD_HAS_BUBBLE: assert (idExBubble); // R7
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hu_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] idRs1,
  input  logic [RW-1:0] idRs2,
  input  logic [RW-1:0] exRs1,
  input  logic [RW-1:0] exRs2,
  input  logic [RW-1:0] exRd,
  input  logic          exRegWrite,
  input  logic          exMemRead,
  input  logic [RW-1:0] memRd,
  input  logic          memRegWrite,
  input  logic [RW-1:0] wbRd,
  input  logic          wbRegWrite,
  input  logic          branchTaken,
  output logic [1:0]    fwdA,
  output logic [1:0]    fwdB,
  output logic          pcHold,
  output logic          ifIdHold,
  output logic          ifIdFlush,
  output logic          idExBubble
);
  localparam int NS = 2;

  logic [RW-1:0] exSrc [NS];
  logic [RW-1:0] idSrc [NS];
  fwdSel_e       fwdSel [NS];
  hzStrobe_t     strobes;

  assign exSrc[0] = exRs1;
  assign exSrc[1] = exRs2;
  assign idSrc[0] = idRs1;
  assign idSrc[1] = idRs2;

  hu_fwd_path #(.RW(RW), .NS(NS)) u_path (
    .exSrc      (exSrc),
    .idSrc      (idSrc),
    .exRd       (exRd),
    .exRegWrite (exRegWrite),
    .exMemRead  (exMemRead),
    .memRd      (memRd),
    .memRegWrite(memRegWrite),
    .wbRd       (wbRd),
    .wbRegWrite (wbRegWrite),
    .branchTaken(branchTaken),
    .fwdSel     (fwdSel),
    .strobes    (strobes)
  );

  hu_ctrl u_ctrl (
    .strobes   (strobes),
    .pcHold    (pcHold),
    .ifIdHold  (ifIdHold),
    .ifIdFlush (ifIdFlush),
    .idExBubble(idExBubble)
  );

  assign fwdA = fwdSel[0];
  assign fwdB = fwdSel[1];

  always_comb begin
    if (branchTaken)
      AST_BRANCH_FLUSH: assert (ifIdFlush && !pcHold); // R9
  end
endmodule

// File: tb/sim_hazard_unit.sv
`timescale 1ns/1ps
module sim_hazard_unit;
  typedef struct packed {
    logic [4:0] idRs1;
    logic [4:0] idRs2;
    logic [4:0] exRs1;
    logic [4:0] exRs2;
    logic [4:0] exRd;
    logic       exRegWrite;
    logic       exMemRead;
    logic [4:0] memRd;
    logic       memRegWrite;
    logic [4:0] wbRd;
    logic       wbRegWrite;
    logic       branchTaken;
    logic [7:0] expOut;   // {fwdA, fwdB, pcHold, ifIdHold, ifIdFlush, idExBubble}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R2 operand A from exec/mem
    '{5'd0, 5'd0, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 1'b0, 8'b10_00_0000, 4'd2},
    // R2 operand B from exec/mem
    '{5'd0, 5'd0, 5'd1, 5'd7, 5'd0, 1'b0, 1'b0, 5'd7, 1'b1, 5'd0, 1'b0, 1'b0, 8'b00_10_0000, 4'd2},
    // R3 operand A from write-back
    '{5'd0, 5'd0, 5'd5, 5'd6, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 5'd5, 1'b1, 1'b0, 8'b01_00_0000, 4'd3},
    // R4 both stages match both operands
    '{5'd0, 5'd0, 5'd6, 5'd6, 5'd0, 1'b0, 1'b0, 5'd6, 1'b1, 5'd6, 1'b1, 1'b0, 8'b10_10_0000, 4'd4},
    // R6 A from write-back, B from exec/mem
    '{5'd0, 5'd0, 5'd8, 5'd9, 5'd0, 1'b0, 1'b0, 5'd9, 1'b1, 5'd8, 1'b1, 1'b0, 8'b01_10_0000, 4'd6},
    // R5 register 0 never forwarded
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 8'b00_00_0000, 4'd5},
    // R5 exec/mem write flag clear falls to write-back
    '{5'd0, 5'd0, 5'd3, 5'd2, 5'd0, 1'b0, 1'b0, 5'd3, 1'b0, 5'd3, 1'b1, 1'b0, 8'b01_00_0000, 4'd5},
    // R7 load-use through idRs1
    '{5'd2, 5'd4, 5'd0, 5'd0, 5'd2, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_00_1101, 4'd7},
    // R7 load-use through idRs2
    '{5'd1, 5'd12, 5'd0, 5'd0, 5'd12, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_00_1101, 4'd7},
    // R8 non-load producer, no stall
    '{5'd2, 5'd2, 5'd0, 5'd0, 5'd2, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_00_0000, 4'd8},
    // R5 load to register 0, no stall
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_00_0000, 4'd5},
    // R9 taken branch flushes
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 8'b00_00_0010, 4'd9},
    // R10 flush beats freeze
    '{5'd3, 5'd0, 5'd0, 5'd0, 5'd3, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 8'b00_00_0011, 4'd10},
    // R5 load with write flag clear, no stall
    '{5'd6, 5'd6, 5'd0, 5'd0, 5'd6, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_00_0000, 4'd5},
    // R1 all zero
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_00_0000, 4'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] idRs1, idRs2, exRs1, exRs2, exRd, memRd, wbRd;
  logic exRegWrite, exMemRead, memRegWrite, wbRegWrite, branchTaken;
  logic [1:0] fwdA, fwdB;
  logic pcHold, ifIdHold, ifIdFlush, idExBubble;

  hazard_unit u0 (
    .idRs1(idRs1), .idRs2(idRs2), .exRs1(exRs1), .exRs2(exRs2),
    .exRd(exRd), .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd),
    .wbRegWrite(wbRegWrite), .branchTaken(branchTaken),
    .fwdA(fwdA), .fwdB(fwdB), .pcHold(pcHold), .ifIdHold(ifIdHold),
    .ifIdFlush(ifIdFlush), .idExBubble(idExBubble)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] outBus();
    return {fwdA, fwdB, pcHold, ifIdHold, ifIdFlush, idExBubble};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    idRs1 = v.idRs1; idRs2 = v.idRs2; exRs1 = v.exRs1; exRs2 = v.exRs2;
    exRd = v.exRd; exRegWrite = v.exRegWrite; exMemRead = v.exMemRead;
    memRd = v.memRd; memRegWrite = v.memRegWrite; wbRd = v.wbRd;
    wbRegWrite = v.wbRegWrite; branchTaken = v.branchTaken;
    @(negedge clk);
  endtask

  initial begin
    idRs1 = '0; idRs2 = '0; exRs1 = '0; exRs2 = '0; exRd = '0; memRd = '0; wbRd = '0;
    exRegWrite = 1'b0; exMemRead = 1'b0; memRegWrite = 1'b0; wbRegWrite = 1'b0;
    branchTaken = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 idle after reset", outBus(), 8'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), outBus(), VECS[i].expOut);
    end

    // R2 highest register number forwarded on both operands
    apply('{5'd0, 5'd0, 5'd31, 5'd31, 5'd0, 1'b0, 1'b0, 5'd31, 1'b1, 5'd30, 1'b1, 1'b0, 8'b0, 4'd2});
    check("R2 register 31", outBus(), 8'b10_10_0000);
    // R4 priority on operand B only, A from register file
    apply('{5'd0, 5'd0, 5'd14, 5'd15, 5'd0, 1'b0, 1'b0, 5'd15, 1'b1, 5'd15, 1'b1, 1'b0, 8'b0, 4'd4});
    check("R4 exec/mem wins on B", outBus(), 8'b00_10_0000);
    // R5 write-back to register 0 ignored
    apply('{5'd0, 5'd0, 5'd0, 5'd1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 8'b0, 4'd5});
    check("R5 write-back r0 ignored", outBus(), 8'b0);
    // R7 load-use combined with forwarding of the execute-stage operand
    apply('{5'd9, 5'd9, 5'd4, 5'd0, 5'd9, 1'b1, 1'b1, 5'd4, 1'b1, 5'd0, 1'b0, 1'b0, 8'b0, 4'd7});
    check("R7 stall with forward", outBus(), 8'b10_00_1101);
    // R8 load to a register that decode does not read
    apply('{5'd2, 5'd3, 5'd0, 5'd0, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 8'b0, 4'd8});
    check("R8 unrelated load no stall", outBus(), 8'b0);
    // R9 flush with forwarding active
    apply('{5'd0, 5'd0, 5'd7, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd7, 1'b1, 1'b1, 8'b0, 4'd9});
    check("R9 flush with forward", outBus(), 8'b01_00_0010);
    // R1 return to idle
    apply('{default: '0});
    check("R1 back to idle", outBus(), 8'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule